// File: doc/BRIEF.md
# Gigabit PCS Management Register File

This block is the software-visible control and status word file for a gigabit physical coding sublayer that runs either as 1000BASE-X or as SGMII. A host reaches it through a simple word-addressed slave port with 16-bit data. Writes take effect at the clock edge on which the write strobe is sampled. Read data is registered and appears one cycle after the read strobe. On its hardware side the block drives the configuration the PCS needs: the operating mode, the speed source, the manual speed code, the ability word it advertises during negotiation, the 21-bit negotiation link timer and the two latency-block reset levels. It also drives two command request levels, one for soft reset and one for negotiation restart.

The block takes in status from the PCS and shows it to software. This status covers negotiation completion, link state, the captured partner ability word, a partner-page event strobe and the latency measurement values. Three bits follow a small two-state machine each, with states `SC_IDLE` and `SC_PEND`. These are the soft-reset command, the negotiation-restart command and the page-received flag. The transition `SC_IDLE -> SC_PEND` is taken on a set request: a write of 1 for a command, or the page event for the flag. The transition `SC_PEND -> SC_IDLE` is taken on a clear event with no set request in the same cycle. The clear event is the hardware done or acknowledge for a command, and a read of the expansion word for the flag. In every other case the state is held, so a set request always beats a clear event in the same cycle.

Top module: `pcs_mgmt_regs`

## Requirements
- R1: After reset the control word reads 0x0000, the ability word reads 0x01A0, the link timer output is 0x98A00, the mode word, scratch word and latency reset bits read 0, and the read data output is 0.
- R2: The read data for a read strobe appears on the cycle after it and holds while no read is strobed. Words 0x07 to 0x0F, 0x15 and 0x16 read 0, and writes to them change no readable word.
- R3: Writing 1 to control word 0x00 bit 15 sets the soft-reset request. Writing 0 there does not clear it. The request stays set until a cycle with `soft_reset_done` high clears it, and it changes no other register.
- R4: Writing 1 to control bit 9 sets the negotiation-restart request, which clears after a cycle with `an_restart_ack` high. Control bit 12 is a plain read/write negotiation enable that drives `an_enable`.
- R5: When a set request and a clear event for a command bit or for the page flag fall in the same cycle, the bit is set afterwards.
- R6: Status word 0x01 reads negotiation-complete in bit 5, a constant 1 in bit 3 and link status in bit 2, with every other bit 0.
- R7: Ability word 0x04 keeps only bits 13:12, 8:7 and 5 (mask 0x31A0). Its value drives `adv_ability`.
- R8: Expansion word 0x06 bit 1 is the page flag. A `page_rx_evt` pulse sets it, and a read of 0x06 returns the flag and then clears it. Bit 0 shows `partner_an_able`.
- R9: Next-page words 0x07 and 0x08 always read 0.
- R10: Scratch word 0x10 stores all 16 written bits.
- R11: The link timer is word 0x12 (bits 15:0) and word 0x13 bits 4:0 (timer bits 20:16). It changes only on a write.
- R12: Mode word 0x14 bit 0 drives `sgmii_mode`, bit 1 drives `use_partner_speed` and bits 3:2 drive `manual_speed`.
- R13: Word 0x17 shows TX and RX measurement-valid in bits 0 and 1. Bits 2 (TX) and 3 (RX) are latency reset levels that hold until rewritten. Words 0x18/0x19, 0x1A/0x1B, 0x1C/0x1D and 0x1E/0x1F hold the TX and RX datapath and PCS latencies, low word first.
- R14: Word 0x05 reads `partner_word`. Words 0x02 and 0x03 read the high and low halves of `PHY_ID`, and word 0x11 reads `REV_ID`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_addr | input | ADDR_W | Word address |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Registered read data |
| soft_reset_req | output | 1 | Soft-reset request level |
| an_restart_req | output | 1 | Negotiation restart request level |
| an_enable | output | 1 | Negotiation enable |
| sgmii_mode | output | 1 | 1 = SGMII, 0 = 1000BASE-X |
| use_partner_speed | output | 1 | Speed taken from partner abilities |
| manual_speed | output | 2 | Manual speed code |
| adv_ability | output | 16 | Advertised ability word |
| link_timer | output | 21 | Negotiation link timer value |
| tx_lat_rst | output | 1 | TX latency block reset level |
| rx_lat_rst | output | 1 | RX latency block reset level |
| soft_reset_done | input | 1 | Soft reset finished |
| an_restart_ack | input | 1 | Negotiation restart has begun |
| an_complete | input | 1 | Negotiation complete |
| link_up | input | 1 | Link established |
| partner_word | input | 16 | Captured partner ability word |
| partner_an_able | input | 1 | Partner can negotiate |
| page_rx_evt | input | 1 | Partner ability word updated |
| tx_meas_valid | input | 1 | TX latency measurement valid |
| rx_meas_valid | input | 1 | RX latency measurement valid |
| tx_dl_lat | input | 21 | TX datapath latency |
| rx_dl_lat | input | 21 | RX datapath latency |
| tx_pcs_lat | input | 22 | TX PCS latency |
| rx_pcs_lat | input | 22 | RX PCS latency |

## Verification
The properties assume that all strobes and status inputs are known after reset. They also assume that the done and acknowledge handshakes may arrive in any cycle, including cycles with no pending request and cycles that carry a new set request. Read and write strobes may coincide, and a read then returns the value before the write. The stimulus draws addresses over the whole word space and toggles every handshake and status input freely from a seeded generator, so every allowed combination of these inputs occurs. Directed sequences place set-against-clear collisions and read-clear-against-page-event collisions on exact cycles.

// File: rtl/pcs_mgmt_pkg.sv
package pcs_mgmt_pkg;

    localparam int unsigned DW = 16;
    localparam int unsigned TIMER_W = 21;

    typedef enum logic {
        SC_IDLE = 1'b0,
        SC_PEND = 1'b1
    } sc_state_e;

    // word addresses
    localparam int unsigned A_CTRL    = 'h00;
    localparam int unsigned A_STAT    = 'h01;
    localparam int unsigned A_ID_HI   = 'h02;
    localparam int unsigned A_ID_LO   = 'h03;
    localparam int unsigned A_ABIL    = 'h04;
    localparam int unsigned A_PARTNER = 'h05;
    localparam int unsigned A_EXPAN   = 'h06;
    localparam int unsigned A_SCRATCH = 'h10;
    localparam int unsigned A_REV     = 'h11;
    localparam int unsigned A_TMR_LO  = 'h12;
    localparam int unsigned A_TMR_HI  = 'h13;
    localparam int unsigned A_MODE    = 'h14;
    localparam int unsigned A_LATCTL  = 'h17;
    localparam int unsigned A_TXDL_LO = 'h18;
    localparam int unsigned A_TXDL_HI = 'h19;
    localparam int unsigned A_RXDL_LO = 'h1A;
    localparam int unsigned A_RXDL_HI = 'h1B;
    localparam int unsigned A_TXPC_LO = 'h1C;
    localparam int unsigned A_TXPC_HI = 'h1D;
    localparam int unsigned A_RXPC_LO = 'h1E;
    localparam int unsigned A_RXPC_HI = 'h1F;

    // control bit positions
    localparam int unsigned B_SRST  = 15;
    localparam int unsigned B_ANEN  = 12;
    localparam int unsigned B_RSTRT = 9;

    localparam logic [DW-1:0]      ABIL_MASK = 16'h31A0;
    localparam logic [DW-1:0]      ABIL_RST  = 16'h01A0;
    localparam logic [TIMER_W-1:0] TIMER_RST = 21'h98A00;

    // self-clearing bit slots
    localparam int unsigned SC_SRST  = 0;
    localparam int unsigned SC_RSTRT = 1;
    localparam int unsigned SC_PAGE  = 2;
    localparam int unsigned SC_NUM   = 3;

endpackage

// File: rtl/pcs_cmd_fsm.sv
module pcs_cmd_fsm
    import pcs_mgmt_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic bit_o
);

    sc_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SC_IDLE;
        else        state_q <= state_d;
    end

    // next state: a set request always wins over a clear event
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SC_IDLE: if (set_i)            state_d = SC_PEND;
            SC_PEND: if (clr_i && !set_i)  state_d = SC_IDLE;
            default:                       state_d = SC_IDLE;
        endcase
    end

    always_comb begin
        bit_o = (state_q == SC_PEND);
    end

endmodule

// File: rtl/pcs_cfg_regs.sv
module pcs_cfg_regs
    import pcs_mgmt_pkg::*;
#(
    parameter int unsigned ADDR_W = 5
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DW-1:0]      wdata,
    output logic               an_en_o,
    output logic [DW-1:0]      abil_o,
    output logic [DW-1:0]      scratch_o,
    output logic [TIMER_W-1:0] timer_o,
    output logic [3:0]         mode_o,
    output logic [1:0]         latrst_o
);

    localparam int unsigned TIMER_HI_W = TIMER_W - DW;

    logic hit_ctrl, hit_abil, hit_scr, hit_tlo, hit_thi, hit_mode, hit_lat;

    always_comb begin
        hit_ctrl = wr_en && (addr == ADDR_W'(A_CTRL));
        hit_abil = wr_en && (addr == ADDR_W'(A_ABIL));
        hit_scr  = wr_en && (addr == ADDR_W'(A_SCRATCH));
        hit_tlo  = wr_en && (addr == ADDR_W'(A_TMR_LO));
        hit_thi  = wr_en && (addr == ADDR_W'(A_TMR_HI));
        hit_mode = wr_en && (addr == ADDR_W'(A_MODE));
        hit_lat  = wr_en && (addr == ADDR_W'(A_LATCTL));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            an_en_o   <= 1'b0;
            abil_o    <= ABIL_RST;
            scratch_o <= '0;
            timer_o   <= TIMER_RST;
            mode_o    <= '0;
            latrst_o  <= '0;
        end else begin
            if (hit_ctrl) an_en_o   <= wdata[B_ANEN];
            if (hit_abil) abil_o    <= wdata & ABIL_MASK;
            if (hit_scr)  scratch_o <= wdata;
            if (hit_tlo)  timer_o[DW-1:0] <= wdata;
            if (hit_thi)  timer_o[TIMER_W-1:DW] <= wdata[TIMER_HI_W-1:0];
            if (hit_mode) mode_o    <= wdata[3:0];
            if (hit_lat)  latrst_o  <= wdata[3:2];
        end
    end

endmodule

// File: rtl/pcs_rd_mux.sv
module pcs_rd_mux
    import pcs_mgmt_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter logic [31:0] PHY_ID = 32'h0141_0C51,
    parameter logic [15:0] REV_ID = 16'h0203
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic               srst,
    input  logic               rstrt,
    input  logic               page,
    input  logic               an_en,
    input  logic [DW-1:0]      abil,
    input  logic [DW-1:0]      scratch,
    input  logic [TIMER_W-1:0] timer,
    input  logic [3:0]         mode,
    input  logic [1:0]         latrst,
    input  logic               an_complete,
    input  logic               link_up,
    input  logic [DW-1:0]      partner_word,
    input  logic               partner_an_able,
    input  logic               tx_mv,
    input  logic               rx_mv,
    input  logic [20:0]        tx_dl,
    input  logic [20:0]        rx_dl,
    input  logic [21:0]        tx_pc,
    input  logic [21:0]        rx_pc,
    output logic [DW-1:0]      rdata
);

    logic [DW-1:0] word;

    always_comb begin
        word = '0;
        case (addr)
            ADDR_W'(A_CTRL): begin
                word[B_SRST]  = srst;
                word[B_ANEN]  = an_en;
                word[B_RSTRT] = rstrt;
            end
            ADDR_W'(A_STAT): begin
                word[5] = an_complete;
                word[3] = 1'b1;
                word[2] = link_up;
            end
            ADDR_W'(A_ID_HI):   word = PHY_ID[31:16];
            ADDR_W'(A_ID_LO):   word = PHY_ID[15:0];
            ADDR_W'(A_ABIL):    word = abil;
            ADDR_W'(A_PARTNER): word = partner_word;
            ADDR_W'(A_EXPAN):   word = {14'd0, page, partner_an_able};
            ADDR_W'(A_SCRATCH): word = scratch;
            ADDR_W'(A_REV):     word = REV_ID;
            ADDR_W'(A_TMR_LO):  word = timer[DW-1:0];
            ADDR_W'(A_TMR_HI):  word = {{(2*DW-TIMER_W){1'b0}}, timer[TIMER_W-1:DW]};
            ADDR_W'(A_MODE):    word = {12'd0, mode};
            ADDR_W'(A_LATCTL):  word = {12'd0, latrst, rx_mv, tx_mv};
            ADDR_W'(A_TXDL_LO): word = tx_dl[15:0];
            ADDR_W'(A_TXDL_HI): word = {11'd0, tx_dl[20:16]};
            ADDR_W'(A_RXDL_LO): word = rx_dl[15:0];
            ADDR_W'(A_RXDL_HI): word = {11'd0, rx_dl[20:16]};
            ADDR_W'(A_TXPC_LO): word = tx_pc[15:0];
            ADDR_W'(A_TXPC_HI): word = {10'd0, tx_pc[21:16]};
            ADDR_W'(A_RXPC_LO): word = rx_pc[15:0];
            ADDR_W'(A_RXPC_HI): word = {10'd0, rx_pc[21:16]};
            default:            word = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= word;
    end

endmodule

// File: rtl/pcs_mgmt_regs.sv
module pcs_mgmt_regs
    import pcs_mgmt_pkg::*;
#(
    parameter int unsigned ADDR_W = 5,
    parameter logic [31:0] PHY_ID = 32'h0141_0C51,
    parameter logic [15:0] REV_ID = 16'h0203
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              soft_reset_req,
    output logic              an_restart_req,
    output logic              an_enable,
    output logic              sgmii_mode,
    output logic              use_partner_speed,
    output logic [1:0]        manual_speed,
    output logic [15:0]       adv_ability,
    output logic [20:0]       link_timer,
    output logic              tx_lat_rst,
    output logic              rx_lat_rst,
    input  logic              soft_reset_done,
    input  logic              an_restart_ack,
    input  logic              an_complete,
    input  logic              link_up,
    input  logic [15:0]       partner_word,
    input  logic              partner_an_able,
    input  logic              page_rx_evt,
    input  logic              tx_meas_valid,
    input  logic              rx_meas_valid,
    input  logic [20:0]       tx_dl_lat,
    input  logic [20:0]       rx_dl_lat,
    input  logic [21:0]       tx_pcs_lat,
    input  logic [21:0]       rx_pcs_lat
);

    logic [SC_NUM-1:0] sc_set, sc_clr, sc_bit;
    logic              wr_ctrl;
    logic [DW-1:0]     scratch_q;
    logic [3:0]        mode_q;
    logic [1:0]        latrst_q;

    always_comb begin
        wr_ctrl          = reg_wr && (reg_addr == ADDR_W'(A_CTRL));
        sc_set[SC_SRST]  = wr_ctrl && reg_wdata[B_SRST];
        sc_clr[SC_SRST]  = soft_reset_done;
        sc_set[SC_RSTRT] = wr_ctrl && reg_wdata[B_RSTRT];
        sc_clr[SC_RSTRT] = an_restart_ack;
        sc_set[SC_PAGE]  = page_rx_evt;
        sc_clr[SC_PAGE]  = reg_rd && (reg_addr == ADDR_W'(A_EXPAN));
    end

    for (genvar g = 0; g < SC_NUM; g++) begin : g_sc
        pcs_cmd_fsm u_bit (
            .clk   (clk),
            .rst_n (rst_n),
            .set_i (sc_set[g]),
            .clr_i (sc_clr[g]),
            .bit_o (sc_bit[g])
        );
    end

    pcs_cfg_regs #(.ADDR_W(ADDR_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr),
        .addr      (reg_addr),
        .wdata     (reg_wdata),
        .an_en_o   (an_enable),
        .abil_o    (adv_ability),
        .scratch_o (scratch_q),
        .timer_o   (link_timer),
        .mode_o    (mode_q),
        .latrst_o  (latrst_q)
    );

    pcs_rd_mux #(.ADDR_W(ADDR_W), .PHY_ID(PHY_ID), .REV_ID(REV_ID)) u_rd (
        .clk             (clk),
        .rst_n           (rst_n),
        .rd_en           (reg_rd),
        .addr            (reg_addr),
        .srst            (sc_bit[SC_SRST]),
        .rstrt           (sc_bit[SC_RSTRT]),
        .page            (sc_bit[SC_PAGE]),
        .an_en           (an_enable),
        .abil            (adv_ability),
        .scratch         (scratch_q),
        .timer           (link_timer),
        .mode            (mode_q),
        .latrst          (latrst_q),
        .an_complete     (an_complete),
        .link_up         (link_up),
        .partner_word    (partner_word),
        .partner_an_able (partner_an_able),
        .tx_mv           (tx_meas_valid),
        .rx_mv           (rx_meas_valid),
        .tx_dl           (tx_dl_lat),
        .rx_dl           (rx_dl_lat),
        .tx_pc           (tx_pcs_lat),
        .rx_pc           (rx_pcs_lat),
        .rdata           (reg_rdata)
    );

    always_comb begin
        soft_reset_req    = sc_bit[SC_SRST];
        an_restart_req    = sc_bit[SC_RSTRT];
        sgmii_mode        = mode_q[0];
        use_partner_speed = mode_q[1];
        manual_speed      = mode_q[3:2];
        tx_lat_rst        = latrst_q[0];
        rx_lat_rst        = latrst_q[1];
    end

endmodule

// File: rtl/pcs_mgmt_chk.sv
module pcs_mgmt_chk #(
    parameter int unsigned ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic              reg_rd,
    input logic [15:0]       reg_wdata,
    input logic [15:0]       reg_rdata,
    input logic              soft_reset_req,
    input logic              an_restart_req,
    input logic              soft_reset_done,
    input logic              an_restart_ack,
    input logic              an_complete,
    input logic              link_up,
    input logic              page_rx_evt,
    input logic              page_flag,
    input logic [20:0]       link_timer
);

    logic wr_srst, rd_expan;
    always_comb begin
        wr_srst  = reg_wr && (reg_addr == ADDR_W'(0)) && reg_wdata[15];
        rd_expan = reg_rd && (reg_addr == ADDR_W'(6));
    end

    AST_RDATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n) !reg_rd |=> $stable(reg_rdata)); // R2
    AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (reg_rd && reg_addr >= ADDR_W'(9) && reg_addr <= ADDR_W'(15)) |=> (reg_rdata == 16'h0)); // R2
    AST_SRST_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (soft_reset_req && !soft_reset_done) |=> soft_reset_req); // R3
    AST_SRST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (soft_reset_req && soft_reset_done && !wr_srst) |=> !soft_reset_req); // R3
    AST_RSTRT_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (an_restart_req && !an_restart_ack) |=> an_restart_req); // R4
    AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n) (wr_srst && soft_reset_done) |=> soft_reset_req); // R5
    AST_STATUS_FMT: assert property (@(posedge clk) disable iff (!rst_n) (reg_rd && reg_addr == ADDR_W'(1)) |=> (reg_rdata[3] && ((reg_rdata & 16'hFFD3) == 16'h0) && reg_rdata[5] == $past(an_complete) && reg_rdata[2] == $past(link_up))); // R6
    AST_PAGE_SET: assert property (@(posedge clk) disable iff (!rst_n) page_rx_evt |=> page_flag); // R8
    AST_PAGE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n) (rd_expan && !page_rx_evt) |=> !page_flag); // R8
    AST_NEXT_PAGE_ZERO: assert property (@(posedge clk) disable iff (!rst_n) (reg_rd && (reg_addr == ADDR_W'(7) || reg_addr == ADDR_W'(8))) |=> (reg_rdata == 16'h0)); // R9
    AST_TIMER_STABLE: assert property (@(posedge clk) disable iff (!rst_n) !reg_wr |=> $stable(link_timer)); // R11

endmodule

bind pcs_mgmt_regs pcs_mgmt_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .reg_addr        (reg_addr),
    .reg_wr          (reg_wr),
    .reg_rd          (reg_rd),
    .reg_wdata       (reg_wdata),
    .reg_rdata       (reg_rdata),
    .soft_reset_req  (soft_reset_req),
    .an_restart_req  (an_restart_req),
    .soft_reset_done (soft_reset_done),
    .an_restart_ack  (an_restart_ack),
    .an_complete     (an_complete),
    .link_up         (link_up),
    .page_rx_evt     (page_rx_evt),
    .page_flag       (sc_bit[2]),
    .link_timer      (link_timer)
);

// File: tb/sim_pcs_mgmt_regs.sv
module sim_pcs_mgmt_regs;

    localparam int unsigned AW = 5;
    localparam logic [31:0] ID = 32'h0141_0C51;
    localparam logic [15:0] RV = 16'h0203;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic          rst_n = 1'b0;
    logic [AW-1:0] reg_addr = '0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic          soft_reset_req, an_restart_req, an_enable, sgmii_mode, use_partner_speed;
    logic [1:0]    manual_speed;
    logic [15:0]   adv_ability;
    logic [20:0]   link_timer;
    logic          tx_lat_rst, rx_lat_rst;
    logic          soft_reset_done = 0, an_restart_ack = 0, an_complete = 0, link_up = 0;
    logic [15:0]   partner_word = '0;
    logic          partner_an_able = 0, page_rx_evt = 0, tx_meas_valid = 0, rx_meas_valid = 0;
    logic [20:0]   tx_dl_lat = '0, rx_dl_lat = '0;
    logic [21:0]   tx_pcs_lat = '0, rx_pcs_lat = '0;

    pcs_mgmt_regs #(.ADDR_W(AW), .PHY_ID(ID), .REV_ID(RV)) u0 (.*);

    int  n_chk = 0, n_bad = 0;
    bit  finished = 0;

    // reference model state
    logic        m_srst = 0, m_rstrt = 0, m_pg = 0, m_anen = 0;
    logic [15:0] m_adv = 16'h01A0, m_scr = 16'h0, m_tlo = 16'h8A00;
    logic [4:0]  m_thi = 5'h09;
    logic [3:0]  m_ifm = 4'h0;
    logic [1:0]  m_dl = 2'b00;
    logic [15:0] last_rd = 16'h0;

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", rq, act, exp, $time);
        end
    endtask

    function automatic logic [15:0] exp_rd(input logic [4:0] a);
        case (a)
            5'h00: return {m_srst, 2'b00, m_anen, 2'b00, m_rstrt, 9'h000};
            5'h01: return {10'h0, an_complete, 1'b0, 1'b1, link_up, 2'b00};
            5'h02: return ID[31:16];
            5'h03: return ID[15:0];
            5'h04: return m_adv;
            5'h05: return partner_word;
            5'h06: return {14'h0, m_pg, partner_an_able};
            5'h10: return m_scr;
            5'h11: return RV;
            5'h12: return m_tlo;
            5'h13: return {11'h0, m_thi};
            5'h14: return {12'h0, m_ifm};
            5'h17: return {12'h0, m_dl, rx_meas_valid, tx_meas_valid};
            5'h18: return tx_dl_lat[15:0];
            5'h19: return {11'h0, tx_dl_lat[20:16]};
            5'h1A: return rx_dl_lat[15:0];
            5'h1B: return {11'h0, rx_dl_lat[20:16]};
            5'h1C: return tx_pcs_lat[15:0];
            5'h1D: return {10'h0, tx_pcs_lat[21:16]};
            5'h1E: return rx_pcs_lat[15:0];
            5'h1F: return {10'h0, rx_pcs_lat[21:16]};
            default: return 16'h0;
        endcase
    endfunction

    function automatic string req_of(input logic [4:0] a);
        case (a)
            5'h00: return "R4";
            5'h01: return "R6";
            5'h02, 5'h03, 5'h05, 5'h11: return "R14";
            5'h04: return "R7";
            5'h06: return "R8";
            5'h07, 5'h08: return "R9";
            5'h10: return "R10";
            5'h12, 5'h13: return "R11";
            5'h14: return "R12";
            5'h17, 5'h18, 5'h19, 5'h1A, 5'h1B, 5'h1C, 5'h1D, 5'h1E, 5'h1F: return "R13";
            default: return "R2";
        endcase
    endfunction

    task automatic hw_idle();
        soft_reset_done = 0; an_restart_ack = 0; page_rx_evt = 0;
    endtask

    // one bus cycle; called at a falling edge
    task automatic step(input logic w, input logic r, input logic [4:0] a, input logic [15:0] d);
        logic [15:0] e;
        logic n_srst, n_rstrt, n_pg;
        reg_wr = w; reg_rd = r; reg_addr = a; reg_wdata = d;
        e = r ? exp_rd(a) : last_rd;
        n_srst  = (w && a == 5'h00 && d[15]) | (m_srst & ~soft_reset_done);
        n_rstrt = (w && a == 5'h00 && d[9]) | (m_rstrt & ~an_restart_ack);
        n_pg    = page_rx_evt | (m_pg & ~(r && a == 5'h06));
        if (w) begin
            case (a)
                5'h00: m_anen = d[12];
                5'h04: m_adv = d & 16'h31A0;
                5'h10: m_scr = d;
                5'h12: m_tlo = d;
                5'h13: m_thi = d[4:0];
                5'h14: m_ifm = d[3:0];
                5'h17: m_dl = d[3:2];
                default: ;
            endcase
        end
        m_srst = n_srst; m_rstrt = n_rstrt; m_pg = n_pg;
        @(posedge clk);
        @(negedge clk);
        last_rd = e;
        chk(r ? req_of(a) : "R2", reg_rdata, e);
        chk("R3", soft_reset_req, m_srst);
        chk("R4", {an_restart_req, an_enable}, {m_rstrt, m_anen});
        chk("R7", adv_ability, m_adv);
        chk("R11", link_timer, {m_thi, m_tlo});
        chk("R12", {manual_speed, use_partner_speed, sgmii_mode}, m_ifm);
        chk("R13", {rx_lat_rst, tx_lat_rst}, m_dl);
        reg_wr = 0; reg_rd = 0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int seed_init;
        seed_init = $urandom(32'd5150);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1", reg_rdata, 16'h0);
        chk("R1", {soft_reset_req, an_restart_req, an_enable}, 3'b000);
        chk("R1", adv_ability, 16'h01A0);
        chk("R1", link_timer, 21'h98A00);
        chk("R1", {manual_speed, use_partner_speed, sgmii_mode, rx_lat_rst, tx_lat_rst}, 6'h0);
        step(0, 1, 5'h00, 0);
        chk("R1", reg_rdata, 16'h0000);
        step(0, 1, 5'h10, 0);

        // R3 soft reset holds, write 0 does not clear, other regs kept
        step(1, 0, 5'h10, 16'hC3A5);
        step(1, 0, 5'h00, 16'h8000);
        step(1, 0, 5'h00, 16'h0000);
        chk("R3", soft_reset_req, 1'b1);
        step(0, 1, 5'h10, 0);
        chk("R3", reg_rdata, 16'hC3A5);
        soft_reset_done = 1;
        step(0, 0, 5'h00, 0);
        hw_idle();
        chk("R3", soft_reset_req, 1'b0);

        // R5 set beats clear in the same cycle
        step(1, 0, 5'h00, 16'h8200);
        soft_reset_done = 1; an_restart_ack = 1;
        step(1, 0, 5'h00, 16'h8200);
        hw_idle();
        chk("R5", {soft_reset_req, an_restart_req}, 2'b11);
        an_restart_ack = 1;
        step(0, 0, 5'h00, 0);
        hw_idle();
        chk("R4", an_restart_req, 1'b0);

        // R8 page flag: set, read clears, read with event keeps it (R5)
        page_rx_evt = 1; step(0, 0, 5'h00, 0); hw_idle();
        step(0, 1, 5'h06, 0);
        chk("R8", reg_rdata[1], 1'b1);
        step(0, 1, 5'h06, 0);
        chk("R8", reg_rdata[1], 1'b0);
        page_rx_evt = 1; step(0, 0, 5'h00, 0);
        step(0, 1, 5'h06, 0); hw_idle();
        step(0, 1, 5'h06, 0);
        chk("R5", reg_rdata[1], 1'b1);

        // R9 next page and R2 reserved words ignore writes
        step(1, 0, 5'h07, 16'hFFFF);
        step(0, 1, 5'h07, 0);
        chk("R9", reg_rdata, 16'h0);
        step(1, 0, 5'h0C, 16'hFFFF);
        step(0, 1, 5'h0C, 0);
        chk("R2", reg_rdata, 16'h0);

        // R7 ability mask, R11 timer halves
        step(1, 0, 5'h04, 16'hFFFF);
        chk("R7", adv_ability, 16'h31A0);
        step(1, 0, 5'h13, 16'hFFFF);
        step(1, 0, 5'h12, 16'h0001);
        chk("R11", link_timer, 21'h1F0001);

        // constrained random traffic
        for (int i = 0; i < 4000; i++) begin
            logic [4:0] a;
            logic w, r;
            a = 5'($urandom_range(0, 31));
            w = ($urandom_range(0, 2) == 0);
            r = ($urandom_range(0, 1) == 0);
            soft_reset_done = ($urandom_range(0, 3) == 0);
            an_restart_ack  = ($urandom_range(0, 3) == 0);
            page_rx_evt     = ($urandom_range(0, 5) == 0);
            an_complete     = 1'($urandom);
            link_up         = 1'($urandom);
            partner_an_able = 1'($urandom);
            tx_meas_valid   = 1'($urandom);
            rx_meas_valid   = 1'($urandom);
            partner_word    = 16'($urandom);
            tx_dl_lat       = 21'($urandom);
            rx_dl_lat       = 21'($urandom);
            tx_pcs_lat      = 22'($urandom);
            rx_pcs_lat      = 22'($urandom);
            step(w, r, a, 16'($urandom));
        end
        hw_idle();
        finish_run();
    end

endmodule